// File: doc/BRIEF.md
# Real-Time Clock with Slow-Domain Register Writes

This block is a memory-mapped real-time clock. It keeps a 47-bit counter in a slow, always-on clock domain that ticks at 32.768 kHz. The upper 32 bits hold whole seconds and the lower 15 bits hold the fraction of a second. A host in a fast bus clock domain programs the time, an alarm and a run control, watches a status word and selects which events drive a single interrupt line.

Every register write except one to the interrupt-enable word is handed across to the slow domain. The block holds one write at a time. A completion flag is raised when the slow side has applied the write, and reading the status word clears that flag. A write that arrives while another is still crossing is dropped and raises an error flag. The interrupt-enable word is written directly in the bus domain and takes effect at once. Reads of slow-domain state come from a bus-side mirror. A request/acknowledge handshake refreshes this mirror all the time, so the seconds and the fraction it returns always belong to the same instant.

The alarm flag is set when the running counter reaches the alarm second with a zero fraction. It stays set until software clears it. The counter stays frozen after reset until the seconds word has been written once, even when the run bit is set.

Top module: `rtc_dual_domain`

## Requirements
- R1: After reset the status word reads 0x203 (bits 9, 1 and 0 set), the interrupt-enable word reads 0, time seconds read 0, alarm seconds read 0xFFFFFFFF, and `irq` is low.
- R2: Word offsets are: time seconds 0x00, time fraction 0x04, alarm seconds 0x08, alarm fraction 0x0C, control 0x10, status 0x14 and interrupt enable 0x18. Control reads back only bit 3. The alarm fraction always reads 0. The interrupt-enable word keeps only bits 9, 8, 7, 4 and 0, and it can be read back on the next access.
- R3: Any write to a word other than interrupt enable starts a transfer. From the next cycle until the transfer ends, status bit 10 (busy) reads 1 and bit 9 (ready for next) reads 0. When the transfer completes, bit 10 returns to 0 and bit 8 (done) is set.
- R4: A write to the interrupt-enable word sets neither busy nor done.
- R5: Any read of the status word clears the done flag.
- R6: A write issued while busy is dropped without effect and sets status bit 7 (error). Writing a 1 to bit 7 of the status word clears the error flag.
- R7: The counter advances once per slow clock only while control bit 3 is 1 and after the seconds word has been written at least once. The fraction wraps from 0x7FFF into a seconds increment.
- R8: Status bit 4 (alarm) is set when the running counter equals the alarm seconds with a zero fraction. The bit stays set until a 1 is written to bit 4 of the status word.
- R9: Status bits 1 (not valid) and 0 (violation) are set by a slow-domain reset. Each is cleared by writing a 1 to its bit of the status word.
- R10: `irq` is the OR of done AND enable bit 8, error AND enable bit 7, alarm AND enable bit 4, violation AND enable bit 0, and ready-for-next AND enable bit 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Host bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| slow_clk | input | 1 | 32.768 kHz timekeeping clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data valid the following cycle |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker watches the bus-side write handshake on every cycle. It checks that an accepted write raises busy, that a write made while busy raises the error flag, that an interrupt-enable write leaves busy clear, that a status read clears done, that done only rises as busy falls, and that `irq` stays low while every enable is off. Behaviour that depends on the slow domain can only be shown by the bench's scenarios: the counter staying frozen until the first seconds write, fraction rollover, the alarm match, flag clearing and mirror readback. The bench also covers random alarm values and random enable masks.

// File: rtl/rtc_pkg.sv
// Shared constants and types for the dual-domain real-time clock.
// Assumes a 32-bit data path and 4-byte word spacing.
package rtc_pkg;
    localparam int SEC_W   = 32;
    localparam int FRAC_W  = 15;
    localparam int CNT_W   = SEC_W + FRAC_W;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int IEN_W   = 10;

    // word index = byte address / 4
    localparam logic [IDX_W-1:0] IX_TSEC  = 3'd0;
    localparam logic [IDX_W-1:0] IX_TFRAC = 3'd1;
    localparam logic [IDX_W-1:0] IX_ASEC  = 3'd2;
    localparam logic [IDX_W-1:0] IX_AFRAC = 3'd3;
    localparam logic [IDX_W-1:0] IX_CTRL  = 3'd4;
    localparam logic [IDX_W-1:0] IX_STAT  = 3'd5;
    localparam logic [IDX_W-1:0] IX_IEN   = 3'd6;
    localparam logic [IDX_W-1:0] IX_NONE  = 3'd7;

    // status / enable bit positions
    localparam int B_BUSY = 10;
    localparam int B_NEXT = 9;
    localparam int B_DONE = 8;
    localparam int B_ERR  = 7;
    localparam int B_ALM  = 4;
    localparam int B_NV   = 1;
    localparam int B_SV   = 0;
    localparam int B_RUN  = 3;

    localparam logic [IEN_W-1:0] IEN_MASK = 10'h391;

    // coherent picture of slow-domain state
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEC_W-1:0] alarm;
        logic             run;
        logic             alm;
        logic             nv;
        logic             sv;
    } slow_view_t;

    localparam slow_view_t VIEW_RESET = '{cnt: '0, alarm: '1, run: 1'b0,
                                          alm: 1'b0, nv: 1'b1, sv: 1'b1};
endpackage

// File: rtl/rtc_sync2.sv
// Two-flop synchroniser for level or toggle signals.
// Assumes each bit is independently meaningful (no multi-bit coherency).
module rtc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // two-stage capture into the destination clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rtc_slow_core.sv
// Slow-domain state: time counter, alarm, run control and sticky flags.
// Applies one bus write per request toggle and answers snapshot toggles.
// Assumes the bus side holds wr_idx/wr_data stable while a request is open.
module rtc_slow_core
    import rtc_pkg::*;
(
    input  logic              sclk,
    input  logic              srst_n,
    input  logic              req_tog_a,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ack_tog,
    input  logic              snap_req_a,
    output logic              snap_tog,
    output slow_view_t        snap
);
    logic             req_s, req_seen, snr_s, snr_seen;
    logic [CNT_W-1:0] cnt;
    logic [SEC_W-1:0] alarm;
    logic             started, run, alm, nv, sv;
    logic             ticking, new_req;

    rtc_sync2 #(.W(1)) u_req  (.clk(sclk), .rst_n(srst_n), .d(req_tog_a),  .q(req_s));
    rtc_sync2 #(.W(1)) u_snr  (.clk(sclk), .rst_n(srst_n), .d(snap_req_a), .q(snr_s));

    assign ticking = run && started;
    assign new_req = req_s ^ req_seen;

    // counting, alarm match and application of crossed writes
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            cnt      <= '0;
            alarm    <= '1;
            started  <= 1'b0;
            run      <= 1'b0;
            alm      <= 1'b0;
            nv       <= 1'b1;
            sv       <= 1'b1;
            req_seen <= 1'b0;
            ack_tog  <= 1'b0;
        end else begin
            if (ticking)
                cnt <= cnt + CNT_W'(1);
            if (ticking && cnt == {alarm, {FRAC_W{1'b0}}})
                alm <= 1'b1;
            if (new_req) begin
                req_seen <= req_s;
                ack_tog  <= ~ack_tog;
                case (wr_idx)
                    IX_TSEC: begin
                        cnt[CNT_W-1:FRAC_W] <= wr_data[SEC_W-1:0];
                        started             <= 1'b1;
                    end
                    IX_TFRAC: cnt[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
                    IX_ASEC:  alarm           <= wr_data[SEC_W-1:0];
                    IX_CTRL:  run             <= wr_data[B_RUN];
                    IX_STAT: begin
                        if (wr_data[B_ALM]) alm <= 1'b0;
                        if (wr_data[B_NV])  nv  <= 1'b0;
                        if (wr_data[B_SV])  sv  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // capture a coherent snapshot whenever the bus side asks for one
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            snap     <= VIEW_RESET;
            snap_tog <= 1'b0;
            snr_seen <= 1'b0;
        end else if (snr_s != snr_seen) begin
            snap     <= '{cnt: cnt, alarm: alarm, run: run, alm: alm, nv: nv, sv: sv};
            snap_tog <= ~snap_tog;
            snr_seen <= snr_s;
        end
    end
endmodule

// File: rtl/rtc_bus_regs.sv
// Bus-domain front end: decode, single-slot write launch, done/error flags,
// interrupt enable, mirror of slow-domain state, read mux and interrupt.
// Assumes one-cycle wr/rd strobes; read data is registered.
module rtc_bus_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              req_tog,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    input  logic              ack_tog_a,
    output logic              snap_req,
    input  logic              snap_tog_a,
    input  slow_view_t        snap,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [IEN_W-1:0]  ien
);
    logic          ack_s, ack_seen, snp_s, done_pulse, xfer_wr;
    slow_view_t    mir;
    logic [DATA_W-1:0] stat_word, rd_mux;

    rtc_sync2 #(.W(1)) u_ack (.clk(clk), .rst_n(rst_n), .d(ack_tog_a),  .q(ack_s));
    rtc_sync2 #(.W(1)) u_snp (.clk(clk), .rst_n(rst_n), .d(snap_tog_a), .q(snp_s));

    assign done_pulse = ack_s ^ ack_seen;
    assign xfer_wr    = wr && idx != IX_IEN && idx != IX_NONE;

    // assemble the status word from local flags and the mirror
    always_comb begin
        stat_word         = '0;
        stat_word[B_BUSY] = busy;
        stat_word[B_NEXT] = !busy;
        stat_word[B_DONE] = done;
        stat_word[B_ERR]  = err;
        stat_word[B_ALM]  = mir.alm;
        stat_word[B_NV]   = mir.nv;
        stat_word[B_SV]   = mir.sv;
    end

    // select read data by word index
    always_comb begin
        rd_mux = '0;
        case (idx)
            IX_TSEC:  rd_mux = mir.cnt[CNT_W-1:FRAC_W];
            IX_TFRAC: rd_mux = {{(DATA_W-FRAC_W){1'b0}}, mir.cnt[FRAC_W-1:0]};
            IX_ASEC:  rd_mux = mir.alarm;
            IX_CTRL:  rd_mux[B_RUN] = mir.run;
            IX_STAT:  rd_mux = stat_word;
            IX_IEN:   rd_mux = {{(DATA_W-IEN_W){1'b0}}, ien};
            default:  rd_mux = '0;
        endcase
    end

    // write launch, completion tracking, flags and read register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tog  <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            ack_seen <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            ien      <= '0;
            rdata    <= '0;
        end else begin
            if (rd)
                rdata <= rd_mux;
            if (done_pulse) begin
                ack_seen <= ack_s;
                busy     <= 1'b0;
            end
            if (rd && idx == IX_STAT)
                done <= 1'b0;
            if (done_pulse)
                done <= 1'b1;
            if (wr && idx == IX_IEN)
                ien <= wdata[IEN_W-1:0] & IEN_MASK;
            if (xfer_wr) begin
                if (busy) begin
                    err <= 1'b1;
                end else begin
                    busy    <= 1'b1;
                    req_tog <= ~req_tog;
                    wr_idx  <= idx;
                    wr_data <= wdata;
                    if (idx == IX_STAT && wdata[B_ERR])
                        err <= 1'b0;
                end
            end
        end
    end

    // keep the mirror refreshed through a request/acknowledge loop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mir      <= VIEW_RESET;
            snap_req <= 1'b0;
        end else if (snp_s == snap_req) begin
            mir      <= snap;
            snap_req <= ~snap_req;
        end
    end

    assign irq = (ien[B_DONE] & done) | (ien[B_ERR] & err) | (ien[B_ALM] & mir.alm) |
                 (ien[B_SV] & mir.sv) | (ien[B_NEXT] & !busy);
endmodule

// File: rtl/rtc_dual_domain.sv
// Top of the dual-domain real-time clock: ties the bus front end to the
// slow-domain timekeeping core. Assumes the two clocks are unrelated.
module rtc_dual_domain
    import rtc_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              req_tog, ack_tog, snap_req, snap_tog;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    slow_view_t        snap;
    logic              w_busy, w_done, w_err;
    logic [IEN_W-1:0]  w_ien;
    logic              unused_lo;

    assign unused_lo = &{1'b0, bus_addr[1:0]};

    rtc_bus_regs u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr(bus_wr), .rd(bus_rd),
        .idx(bus_addr[ADDR_W-1:2]), .wdata(bus_wdata), .rdata(bus_rdata), .irq(irq),
        .req_tog(req_tog), .wr_idx(wr_idx), .wr_data(wr_data), .ack_tog_a(ack_tog),
        .snap_req(snap_req), .snap_tog_a(snap_tog), .snap(snap),
        .busy(w_busy), .done(w_done), .err(w_err), .ien(w_ien)
    );

    rtc_slow_core u_slow (
        .sclk(slow_clk), .srst_n(slow_rst_n), .req_tog_a(req_tog),
        .wr_idx(wr_idx), .wr_data(wr_data), .ack_tog(ack_tog),
        .snap_req_a(snap_req), .snap_tog(snap_tog), .snap(snap)
    );
endmodule

// File: rtl/rtc_dual_domain_chk.sv
// Bus-domain protocol checker for rtc_dual_domain, bound into the top.
module rtc_dual_domain_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              irq,
    input logic [IEN_W-1:0]  ien
);
    logic [IDX_W-1:0] ix;
    logic             xfer, unused_lo;
    assign ix        = addr[ADDR_W-1:2];
    assign xfer      = wr && ix != IX_IEN && ix != IX_NONE;
    assign unused_lo = &{1'b0, addr[1:0]};

    a_r3_write_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !busy) |=> busy);

    a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    a_r4_ien_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ix == IX_IEN && !busy) |=> !busy);

    a_r5_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && ix == IX_STAT && !busy) |=> !done);

    a_r6_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && busy) |=> err);

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

bind rtc_dual_domain rtc_dual_domain_chk u_chk (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .busy(w_busy), .done(w_done), .err(w_err), .irq(irq), .ien(w_ien)
);

// File: tb/sim_rtc_dual_domain.sv
// Self-checking bench for rtc_dual_domain: directed corners plus seeded random.
module sim_rtc_dual_domain;
    localparam logic [4:0] A_TSEC = 5'h00, A_TFRAC = 5'h04, A_ASEC = 5'h08,
                           A_AFRAC = 5'h0C, A_CTRL = 5'h10, A_STAT = 5'h14, A_IEN = 5'h18;

    logic        clk = 1'b0, sclk = 1'b0, rst_n = 1'b0, srst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        irq;
    int          checks = 0, failures = 0;

    always #4  clk  = ~clk;
    always #50 sclk = ~sclk;

    rtc_dual_domain u0 (
        .bus_clk(clk), .bus_rst_n(rst_n), .slow_clk(sclk), .slow_rst_n(srst_n),
        .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq(irq)
    );

    function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] en);
        return (st[8] & en[8]) | (st[7] & en[7]) | (st[4] & en[4]) |
               (st[0] & en[0]) | (st[9] & en[9]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write, then poll status until the done flag appears (R3)
    task automatic sync_write(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] s;
        logic        got = 1'b0;
        bus_write(a, d);
        for (int i = 0; i < 300 && !got; i++) begin
            bus_read(A_STAT, s);
            if (s[8]) got = 1'b1;
        end
        check("R3 write completes with done", {31'd0, got}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, s, m, f1, f2;
        void'($urandom(32'd20240611));
        repeat (50) @(negedge clk);
        rst_n = 1'b1; srst_n = 1'b1;
        settle(5);

        // R1 reset state
        bus_read(A_STAT, v); check("R1 status after reset", v, 32'h203);
        bus_read(A_IEN, v);  check("R1 enable after reset", v, 0);
        bus_read(A_TSEC, v); check("R1 seconds after reset", v, 0);
        bus_read(A_ASEC, v); check("R1 alarm after reset", v, 32'hFFFF_FFFF);
        check("R1 irq after reset", {31'd0, irq}, 0);

        // R9 clear not-valid and violation flags
        sync_write(A_STAT, 32'h3); settle(120);
        bus_read(A_STAT, v); check("R9 nv/sv cleared", v, 32'h200);

        // R3 busy and ready-for-next during a transfer
        bus_write(A_AFRAC, 32'h1234);
        bus_read(A_STAT, v); check("R3 busy set, next clear", v[10:8], 3'b100);
        for (int i = 0; i < 300 && !v[8]; i++) bus_read(A_STAT, v);
        check("R3 done after transfer", {29'd0, v[10:8]}, 32'b011);
        // R5 the read that saw done cleared it
        bus_read(A_STAT, v); check("R5 done cleared by read", {31'd0, v[8]}, 0);
        settle(120);
        bus_read(A_AFRAC, v); check("R2 alarm fraction reads zero", v, 0);

        // R2 control keeps bit 3 only
        sync_write(A_CTRL, 32'hFFFF_FFF7); settle(120);
        bus_read(A_CTRL, v); check("R2 control readback", v, 0);

        // R4 enable write at bus speed, no transfer
        bus_write(A_IEN, 32'hFFFF_FFFF);
        bus_read(A_IEN, v); check("R2 enable mask readback", v, 32'h391);
        bus_read(A_STAT, v); check("R4 enable write no busy", {31'd0, v[10]}, 0);
        settle(120);
        bus_read(A_STAT, v); check("R4 enable write no done", {31'd0, v[8]}, 0);
        bus_write(A_IEN, 0);

        // R6 second write while busy is dropped and flags error
        bus_write(A_ASEC, 32'h1234);
        bus_write(A_ASEC, 32'h5678);
        bus_read(A_STAT, v); check("R6 error on write while busy", {31'd0, v[7]}, 1);
        for (int i = 0; i < 300 && !v[8]; i++) bus_read(A_STAT, v);
        settle(120);
        bus_read(A_ASEC, v); check("R6 dropped write had no effect", v, 32'h1234);
        sync_write(A_STAT, 32'h80);
        bus_read(A_STAT, v); check("R6 error cleared by write one", {31'd0, v[7]}, 0);

        // R7 frozen until seconds written, then rollover
        sync_write(A_TFRAC, 32'h7FF0);
        sync_write(A_CTRL, 32'h8);
        settle(400);
        bus_read(A_TFRAC, v); check("R7 frozen before seconds write", v, 32'h7FF0);
        sync_write(A_TSEC, 32'd100);
        settle(750);
        bus_read(A_TSEC, v);  check("R7 seconds after rollover", v, 32'd101);
        bus_read(A_TFRAC, f1);
        check("R7 fraction small after wrap", {31'd0, (f1 > 0 && f1 < 32'h100)}, 1);
        sync_write(A_CTRL, 0); settle(120);
        bus_read(A_TFRAC, f1); settle(300); bus_read(A_TFRAC, f2);
        check("R7 stopped when run bit clear", f2, f1);

        // R8 alarm match, stickiness, clear; R10 irq from alarm
        sync_write(A_ASEC, 32'd200);
        sync_write(A_TFRAC, 32'h7FC0);
        sync_write(A_TSEC, 32'd199);
        settle(120);
        bus_read(A_STAT, v); check("R8 no alarm while stopped", {31'd0, v[4]}, 0);
        bus_write(A_IEN, 32'h10);
        sync_write(A_CTRL, 32'h8);
        settle(1250);
        bus_read(A_STAT, v); check("R8 alarm flag set", {31'd0, v[4]}, 1);
        check("R10 irq from alarm", {31'd0, irq}, 1);
        settle(300);
        bus_read(A_STAT, v); check("R8 alarm flag sticky", {31'd0, v[4]}, 1);
        sync_write(A_STAT, 32'h10); settle(120);
        bus_read(A_STAT, v); check("R8 alarm flag cleared", {31'd0, v[4]}, 0);
        check("R10 irq drops after clear", {31'd0, irq}, 0);
        sync_write(A_CTRL, 0); settle(120);

        // R2 random alarm values round-trip
        for (int k = 0; k < 8; k++) begin
            m = $urandom;
            sync_write(A_ASEC, m); settle(120);
            bus_read(A_ASEC, v); check("R2 random alarm readback", v, m);
        end

        // R10 random enable masks against status
        for (int k = 0; k < 8; k++) begin
            m = $urandom & 32'h3FF;
            if (k == 0) begin   // raise error flag for a richer status
                bus_write(A_ASEC, 32'h1); bus_write(A_ASEC, 32'h2);
                for (int i = 0; i < 300; i++) begin bus_read(A_STAT, s); if (s[8]) break; end
                settle(120);
            end
            bus_write(A_IEN, m);
            bus_read(A_IEN, v); check("R2 random enable readback", v, m & 32'h391);
            bus_read(A_STAT, s);
            check("R10 irq equals masked flags", {31'd0, irq}, {31'd0, exp_irq(s, m & 32'h391)});
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule